// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Clear-on-Read Status

This block sits between the bit-level deframer of a data-link HDLC receiver and a host register interface. The deframer pushes received bytes into a byte-wide queue. When a frame closes, the deframer pushes one extra byte, the frame-status byte, and marks it as such. The deframer also signals aborted frames and delivers the raw line bits so that the block can spot an idle line. A stored byte is not tagged when transparent mode is on, and no end-of-frame flag is raised in that mode.

The host reads through one select port. It can read the fill-status register, the queue-status register or the data port, and each read of the data port pops one byte. The fill-status register holds four sticky flags: full against a programmable level, end of frame, overrun and line idle. A flag clears only on a read of the register that owns it. The queue-status register reports the total number of queued bytes. When a frame-status byte is waiting, it reports instead how many bytes must be read to reach that byte, counting the byte itself.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the queue is empty, the fill-status register reads 0x00 and the queue-status register reads 0x00.
- R2: Bytes come out of the data port (rdSel = 2) in the order they were pushed, one byte popped per data read.
- R3: A data read while the queue is empty returns 0x00 and leaves the byte count unchanged.
- R4: The queue holds 64 bytes. A byte pushed while 64 are stored is discarded, the stored bytes are kept, and the overrun flag (fill bit 2) is set.
- R5: The full flag (fill bit 0) is set whenever the byte count is at or above fullLevel. It is cleared only by a data read, and a fill-status read leaves it set.
- R6: The end-of-frame flag (fill bit 1) is set by a push marked with wrIsStatus or by an abortPulse. It clears on a fill-status read (rdSel = 0).
- R7: In transparent mode an abort or a status-marked push sets no end-of-frame flag, and the pushed byte is stored as plain data.
- R8: The idle flag (fill bit 3) is set once 15 consecutive 1 bits have been received on lineBit, and it stays clear after a run of only 14. It clears on a fill-status read.
- R9: The queue-status register (rdSel = 1) holds a binary count in bits 6:0 with bit 0 as the LSB. With bit 7 at 0, the count is the total number of bytes. With bit 7 at 1, a frame-status byte is queued and the count is the number of bytes up to and including the first such byte.
- R10: When a flag's set event and its clearing read fall in the same cycle, the flag ends up set.
- R11: Fill-status bits 7:4 always read 0. rdSel = 3 reads 0x00.
- R12: A push and a data pop in the same cycle, with the queue neither empty nor full, leave the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Push strobe from the deframer |
| wrData | input | 8 | Byte to push |
| wrIsStatus | input | 1 | Marks the pushed byte as a frame-status byte (frame closed) |
| abortPulse | input | 1 | One-cycle abort event from the deframer |
| lineBitValid | input | 1 | Qualifies lineBit |
| lineBit | input | 1 | Raw received line bit, used for idle detection |
| transparentMode | input | 1 | Disables frame-status tagging and end-of-frame flagging |
| fullLevel | input | 7 | Programmable full threshold in bytes |
| rdEn | input | 1 | Host read strobe (clear-on-read side effects) |
| rdSel | input | 2 | 0 fill status, 1 queue status, 2 data, 3 none |
| rdData | output | 8 | Read data, valid in the cycle of rdEn |

## Verification
Two cases are hard to reach from the ports. One is the same-cycle collision between a flag's set event and the read that clears it. The bench creates it by raising abortPulse in the same cycle as a fill-status read, then reads again to see the flag survive. The other is the queue-status count after the first frame-status byte has been popped while a second one is still queued. To reach it, the stimulus interleaves two closed frames and pops one byte at a time, comparing each readout against a scan of the bench's own queue model. The overrun case fills the queue to exactly 64 entries and then pushes once more. The scoreboard confirms that the extra byte never appears when the queue is drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // strobes issued by the control section to the storage section
  typedef struct packed {
    logic push;
    logic pop;
    logic tag;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    SEL_FILL  = 2'd0,
    SEL_QSTAT = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_t;

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] count,
  output logic             isEmpty,
  output logic             isFull,
  output logic [7:0]       headByte,
  output logic             tagSeen,
  output logic [CNT_W-1:0] tagDist
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] tagMem;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(1);
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      mem[wrPtr]    <= wrData;
      tagMem[wrPtr] <= strobe.tag;
    end
  end

  assign headByte = mem[rdPtr];
  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));

  // distance from the head to the first tagged (frame-status) entry
  always_comb begin
    logic [PTR_W-1:0] idx;
    tagSeen = 1'b0;
    tagDist = '0;
    idx     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rdPtr + PTR_W'(i);
      if (!tagSeen && (CNT_W'(i) < count) && tagMem[idx]) begin
        tagSeen = 1'b1;
        tagDist = CNT_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CNT_W    = $clog2(DEPTH) + 1,
  parameter int IDLE_RUN = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrIsStatus,
  input  logic             abortPulse,
  input  logic             lineBitValid,
  input  logic             lineBit,
  input  logic             transparentMode,
  input  logic [CNT_W-1:0] fullLevel,
  input  logic             rdEn,
  input  logic [1:0]       rdSel,
  input  logic [CNT_W-1:0] count,
  input  logic             isEmpty,
  input  logic             isFull,
  input  logic [7:0]       headByte,
  input  logic             tagSeen,
  input  logic [CNT_W-1:0] tagDist,
  output dpStrobe_t        strobe,
  output logic [7:0]       rdData
);

  localparam int RUN_W = $clog2(IDLE_RUN + 1);

  logic             fullFlag, eofFlag, ovrFlag, idleFlag;
  logic             readFill, readData;
  logic             fullSet, eofSet, ovrSet, idleSet;
  logic [RUN_W-1:0] onesRun;
  logic [7:0]       fillReg, qStatReg;

  assign readFill = rdEn && (regSel_t'(rdSel) == SEL_FILL);
  assign readData = rdEn && (regSel_t'(rdSel) == SEL_DATA);

  assign strobe.push = wrValid && !isFull;
  assign strobe.pop  = readData && !isEmpty;
  assign strobe.tag  = wrIsStatus && !transparentMode;

  assign fullSet = (count >= fullLevel);
  assign eofSet  = !transparentMode && ((wrValid && wrIsStatus) || abortPulse);
  assign ovrSet  = wrValid && isFull;
  assign idleSet = lineBitValid && lineBit && (onesRun >= RUN_W'(IDLE_RUN - 1));

  // sticky flags: a set in the clearing cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
      eofFlag  <= 1'b0;
      ovrFlag  <= 1'b0;
      idleFlag <= 1'b0;
    end else begin
      fullFlag <= fullSet || (fullFlag && !readData);
      eofFlag  <= eofSet  || (eofFlag  && !readFill);
      ovrFlag  <= ovrSet  || (ovrFlag  && !readFill);
      idleFlag <= idleSet || (idleFlag && !readFill);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun <= '0;
    end else if (lineBitValid) begin
      if (!lineBit)                          onesRun <= '0;
      else if (onesRun != RUN_W'(IDLE_RUN)) onesRun <= onesRun + RUN_W'(1);
    end
  end

  always_comb begin
    fillReg    = '0;
    fillReg[0] = fullFlag;
    fillReg[1] = eofFlag;
    fillReg[2] = ovrFlag;
    fillReg[3] = idleFlag;
    qStatReg   = '0;
    qStatReg[CNT_W-1:0] = tagSeen ? tagDist : count;
    qStatReg[7] = tagSeen;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (regSel_t'(rdSel))
        SEL_FILL:  rdData = fillReg;
        SEL_QSTAT: rdData = qStatReg;
        SEL_DATA:  rdData = isEmpty ? 8'h00 : headByte;
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int IDLE_RUN = 15,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             wrIsStatus,
  input  logic             abortPulse,
  input  logic             lineBitValid,
  input  logic             lineBit,
  input  logic             transparentMode,
  input  logic [CNT_W-1:0] fullLevel,
  input  logic             rdEn,
  input  logic [1:0]       rdSel,
  output logic [7:0]       rdData
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] qCount;
  logic             qEmpty, qFull, tagSeen;
  logic [7:0]       headByte;
  logic [CNT_W-1:0] tagDist;

  rxq_control #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDLE_RUN(IDLE_RUN)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrIsStatus(wrIsStatus), .abortPulse(abortPulse),
    .lineBitValid(lineBitValid), .lineBit(lineBit),
    .transparentMode(transparentMode), .fullLevel(fullLevel),
    .rdEn(rdEn), .rdSel(rdSel),
    .count(qCount), .isEmpty(qEmpty), .isFull(qFull), .headByte(headByte),
    .tagSeen(tagSeen), .tagDist(tagDist),
    .strobe(strobe), .rdData(rdData)
  );

  rxq_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .count(qCount), .isEmpty(qEmpty), .isFull(qFull), .headByte(headByte),
    .tagSeen(tagSeen), .tagDist(tagDist)
  );

endmodule

// File: rtl/rx_frame_queue_chk.sv
module rx_frame_queue_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             rdEn,
  input logic [1:0]       rdSel,
  input logic [7:0]       rdData,
  input logic [CNT_W-1:0] fullLevel,
  input logic [CNT_W-1:0] qCount
);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH));

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd2 && qCount == '0) |-> (rdData == 8'h00));

  // R3
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd2 && qCount == '0 && !wrValid) |=> (qCount == '0));

  // R11
  fill_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd0) |-> (rdData[7:4] == 4'h0));

  // R5
  full_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qCount >= fullLevel) |=> (!(rdEn && rdSel == 2'd0) || rdData[0]));

  // R12
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdEn && rdSel == 2'd2 && qCount != '0 && qCount != CNT_W'(DEPTH))
      |=> (qCount == $past(qCount)));

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && qCount != CNT_W'(DEPTH) && !(rdEn && rdSel == 2'd2))
      |=> (qCount == $past(qCount) + CNT_W'(1)));

endmodule

bind rx_frame_queue rx_frame_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdEn(rdEn), .rdSel(rdSel),
  .rdData(rdData), .fullLevel(fullLevel), .qCount(qCount)
);

// File: tb/rx_frame_queue_test.sv
module rx_frame_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrIsStatus = 1'b0;
  logic       abortPulse = 1'b0;
  logic       lineBitValid = 1'b0;
  logic       lineBit = 1'b0;
  logic       transparentMode = 1'b0;
  logic [6:0] fullLevel = 7'd4;
  logic       rdEn = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;
  logic [8:0] expQ[$];   // {tag, data}
  logic [8:0] ent;
  logic [7:0] expByte;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_frame_queue uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrIsStatus(wrIsStatus), .abortPulse(abortPulse),
    .lineBitValid(lineBitValid), .lineBit(lineBit),
    .transparentMode(transparentMode), .fullLevel(fullLevel),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic check(input logic ok, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // expected queue-status value from the model (R9)
  function automatic logic [7:0] qModel();
    for (int i = 0; i < expQ.size(); i++)
      if (expQ[i][8]) return {1'b1, 7'(i + 1)};
    return {1'b0, 7'(expQ.size())};
  endfunction

  // driver: push one byte, record it in the scoreboard
  task automatic pushByte(input logic [7:0] d, input logic isStat);
    @(posedge clk); #1;
    wrValid = 1'b1; wrData = d; wrIsStatus = isStat;
    if (expQ.size() < DEPTH) expQ.push_back({isStat && !transparentMode, d});
    @(posedge clk); #1;
    wrValid = 1'b0; wrIsStatus = 1'b0;
  endtask

  task automatic readData();
    @(posedge clk); #1;
    rdEn = 1'b1; rdSel = 2'd2;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pushPop(input logic [7:0] d);
    @(posedge clk); #1;
    wrValid = 1'b1; wrData = d; wrIsStatus = 1'b0;
    if (expQ.size() < DEPTH) expQ.push_back({1'b0, d});
    rdEn = 1'b1; rdSel = 2'd2;
    @(posedge clk); #1;
    wrValid = 1'b0; rdEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, input logic [7:0] exp, input string what);
    @(posedge clk); #1;
    rdEn = 1'b1; rdSel = sel;
    @(negedge clk);
    check(rdData == exp, what, rdData, exp);
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic abortWithFillRead();
    @(posedge clk); #1;
    abortPulse = 1'b1; rdEn = 1'b1; rdSel = 2'd0;
    @(negedge clk);
    check(rdData == 8'h00, "R10 read in collision cycle shows old flags", rdData, 8'h00);
    @(posedge clk); #1;
    abortPulse = 1'b0; rdEn = 1'b0;
  endtask

  task automatic abortOnly();
    @(posedge clk); #1;
    abortPulse = 1'b1;
    @(posedge clk); #1;
    abortPulse = 1'b0;
  endtask

  task automatic sendOnes(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      lineBitValid = 1'b1; lineBit = 1'b1;
    end
    @(posedge clk); #1;
    lineBit = 1'b0;
    @(posedge clk); #1;
    lineBitValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) readData();
  endtask

  // monitor: compares every data-port read against the scoreboard
  always @(negedge clk) begin
    if (rdEn && rdSel == 2'd2) begin
      if (expQ.size() == 0) begin
        check(rdData == 8'h00, "R3 empty data read", rdData, 8'h00);
      end else begin
        ent = expQ.pop_front();
        expByte = ent[7:0];
        check(rdData == expByte, "R2 data order", rdData, expByte);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, 8'h00, "R1 fill status after reset");
    readReg(2'd1, 8'h00, "R1 queue status after reset");
    // R3 empty read, count unchanged
    readData();
    readReg(2'd1, 8'h00, "R3 queue status after empty read");
    readReg(2'd3, 8'h00, "R11 unused select reads zero");

    // R5, R6, R9 with full level 4
    pushByte(8'hA1, 1'b0);
    pushByte(8'hA2, 1'b0);
    pushByte(8'hA3, 1'b0);
    readReg(2'd0, 8'h00, "R5 below full level");
    pushByte(8'h5A, 1'b1);
    readReg(2'd0, 8'h03, "R5 R6 full and end-of-frame set");
    readReg(2'd1, qModel(), "R9 count up to first status byte");
    pushByte(8'hB1, 1'b0);
    pushByte(8'hB2, 1'b0);
    readReg(2'd1, qModel(), "R9 count ignores bytes after status byte");
    readReg(2'd0, 8'h01, "R5 full survives fill read, R6 eof cleared");
    readData();
    readReg(2'd0, 8'h01, "R5 full stays while still at level");
    readData();
    readData();
    readData();
    readReg(2'd0, 8'h00, "R5 full cleared by data read below level");
    readReg(2'd1, qModel(), "R9 total count with no status byte");
    drain();
    readReg(2'd0, 8'h00, "R5 flags clear after drain");

    // R4 overflow
    #1 fullLevel = 7'd64;
    for (int i = 0; i < DEPTH; i++) pushByte(8'(i * 3 + 1), 1'b0);
    pushByte(8'hEE, 1'b0);
    readReg(2'd1, 8'h40, "R4 count holds at 64");
    readReg(2'd0, 8'h05, "R4 overrun and full set");
    readReg(2'd0, 8'h01, "R4 overrun cleared by fill read");
    drain();
    readReg(2'd1, 8'h00, "R4 queue empty after drain");
    readReg(2'd0, 8'h00, "R5 full cleared after drain");

    // R7 transparent mode
    #1 transparentMode = 1'b1;
    pushByte(8'h11, 1'b0);
    pushByte(8'h22, 1'b1);
    abortOnly();
    readReg(2'd0, 8'h00, "R7 no end-of-frame in transparent mode");
    readReg(2'd1, 8'h02, "R7 status marker ignored");
    drain();
    #1 transparentMode = 1'b0;

    // R8 idle detection
    sendOnes(14);
    readReg(2'd0, 8'h00, "R8 run of 14 ones not idle");
    sendOnes(15);
    readReg(2'd0, 8'h08, "R8 run of 15 ones sets idle");
    readReg(2'd0, 8'h00, "R8 idle cleared by fill read");

    // R6 abort, R10 set beats clear
    abortOnly();
    readReg(2'd0, 8'h02, "R6 abort sets end-of-frame");
    abortWithFillRead();
    readReg(2'd0, 8'h02, "R10 set wins over clearing read");
    readReg(2'd0, 8'h00, "R10 flag then clears");

    // R12 push and pop together
    pushByte(8'h31, 1'b0);
    pushByte(8'h32, 1'b0);
    pushPop(8'h33);
    readReg(2'd1, 8'h02, "R12 count unchanged by push with pop");
    drain();

    // R9 two frames queued
    pushByte(8'h41, 1'b0);
    pushByte(8'h42, 1'b1);
    pushByte(8'h43, 1'b0);
    pushByte(8'h44, 1'b1);
    readReg(2'd1, qModel(), "R9 first status byte at position 2");
    readData();
    readReg(2'd1, qModel(), "R9 first status byte at head");
    readData();
    readReg(2'd1, qModel(), "R9 second frame status byte now first");
    drain();
    readReg(2'd0, 8'h02, "R6 status push sets end-of-frame");
    readReg(2'd1, 8'h00, "R9 empty after drain");

    finishRun();
  end

endmodule